// File: doc/BRIEF.md
# Sobel Edge Magnitude Engine

This engine turns one grayscale frame held in an external memory into an edge-magnitude frame. The result goes to a second memory. A one-cycle `start` pulse launches a frame. The engine first writes zero to every perimeter pixel of the result. It then walks the interior pixels in row-major order with a single flattened iterator. When the last result is in memory, it raises `done` for one cycle.

The source memory has two synchronous read ports with one cycle of read latency. Each interior pixel needs its eight neighbours; the centre has weight zero in both kernels, so it is never fetched. The eight neighbours are fetched two per cycle, so a new pixel enters the pipeline every four cycles. The arithmetic of one pixel overlaps the fetches of the next.

Top module: `sobel_edge_engine`

## Requirements
- R1: While reset is held and after it is released with no start, `done`, `wr_en`, `rd_en_a` and `rd_en_b` are all low.
- R2: For an interior pixel at (row r, column c), the value written is |Gx| + |Gy|. Gx is (p[r-1][c+1] + 2·p[r][c+1] + p[r+1][c+1]) − (p[r-1][c-1] + 2·p[r][c-1] + p[r+1][c-1]). Gy is (p[r+1][c-1] + 2·p[r+1][c] + p[r+1][c+1]) − (p[r-1][c-1] + 2·p[r-1][c] + p[r-1][c+1]). Every pixel of either memory sits at address r·COLS + c, and read data appears one cycle after the read request.
- R3: A magnitude above 255 is written as 255.
- R4: Every result pixel in row 0, row ROWS−1, column 0 or column COLS−1 is written as 0.
- R5: Each frame writes each of the ROWS·COLS result addresses exactly once.
- R6: Both read ports are active in exactly the same cycles. They carry different addresses inside the frame. A frame uses 4·(ROWS−2)·(COLS−2) read cycles.
- R7: Interior results are written in increasing address order, exactly four cycles apart.
- R8: `done` is high for exactly one cycle, the cycle right after the frame's last write, and no write happens in that cycle.
- R9: A `start` pulse that arrives while a frame is in progress is ignored: the frame completes once, with one `done` and ROWS·COLS writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle pulse that launches a frame when idle |
| done | output | 1 | One-cycle pulse when the frame is complete |
| rd_en_a | output | 1 | Read request, source port A |
| rd_addr_a | output | AW | Read address, source port A |
| rd_data_a | input | 8 | Read data, port A, one cycle after the request |
| rd_en_b | output | 1 | Read request, source port B |
| rd_addr_b | output | AW | Read address, source port B |
| rd_data_b | input | 8 | Read data, port B, one cycle after the request |
| wr_en | output | 1 | Result write strobe |
| wr_addr | output | AW | Result write address |
| wr_data | output | 8 | Result pixel value |

AW is clog2(ROWS·COLS).

## Verification
The bench builds the engine with ROWS = 6 and COLS = 7. The frame is not square, so a swap of row and column arithmetic in an address or in the column wrap shows up as a wrong pixel. The frame is also small, so the perimeter walk, the wrap from the last interior column to the next row, and the final-pixel drain all occur many times within a short run. Frames that are flat, stepped, checkered, low-contrast random and full-range random push the magnitude both below and above the saturation point.

// File: rtl/sobel_pkg.sv
package sobel_pkg;

    localparam int PIX_W  = 8;
    localparam int TAPS   = 8;
    localparam int PHASES = 4;
    localparam int PH_W   = $clog2(PHASES);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RIM,
        ST_CORE,
        ST_DRAIN,
        ST_FIN
    } ctl_state_e;

    // Tap k of a neighbourhood, as a row offset 0..2 (meaning -1..+1).
    // Taps 2p and 2p+1 are fetched in phase p on ports A and B.
    function automatic int tap_dr(input int k);
        if (k < 3)      return 0;
        else if (k < 5) return 1;
        else            return 2;
    endfunction

    // Column offset 0..2 (meaning -1..+1) of tap k.
    function automatic int tap_dc(input int k);
        case (k)
            0, 3, 5: return 0;
            1, 6:    return 1;
            default: return 2;
        endcase
    endfunction

endpackage

// File: rtl/sobel_rim_walk.sv
module sobel_rim_walk #(
    parameter int ROWS = 512,
    parameter int COLS = 512,
    parameter int AW   = 18
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    output logic          act,
    output logic          last,
    output logic [AW-1:0] addr
);

    localparam int RW = $clog2(ROWS);
    localparam int CW = $clog2(COLS);

    typedef struct packed {
        logic          run;
        logic [RW-1:0] row;
        logic [CW-1:0] col;
    } rim_s;

    rim_s q, d;
    logic cap_row;
    logic at_end;

    // Visits only perimeter pixels, row-major: full top and bottom rows,
    // and only the first and last column of every row in between.
    always_comb begin
        d       = q;
        cap_row = (q.row == RW'(0)) || (q.row == RW'(ROWS - 1));
        at_end  = q.run && (q.row == RW'(ROWS - 1)) && (q.col == CW'(COLS - 1));
        if (go) begin
            d.run = 1'b1;
            d.row = '0;
            d.col = '0;
        end else if (q.run) begin
            if (q.col == CW'(COLS - 1)) begin
                d.col = '0;
                if (at_end) d.run = 1'b0;
                else        d.row = q.row + RW'(1);
            end else if (cap_row) begin
                d.col = q.col + CW'(1);
            end else begin
                d.col = CW'(COLS - 1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign act  = q.run;
    assign last = at_end;
    assign addr = AW'(int'(q.row) * COLS + int'(q.col));

endmodule

// File: rtl/sobel_core_walk.sv
module sobel_core_walk
    import sobel_pkg::*;
#(
    parameter int ROWS = 512,
    parameter int COLS = 512,
    parameter int AW   = 18
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            go,
    output logic            rd_en,
    output logic [AW-1:0]   addr_a,
    output logic [AW-1:0]   addr_b,
    output logic [PH_W-1:0] phase,
    output logic [AW-1:0]   ctr_addr,
    output logic            last_issue
);

    localparam int RW = $clog2(ROWS);
    localparam int CW = $clog2(COLS);

    typedef struct packed {
        logic            run;
        logic [RW-1:0]   row;
        logic [CW-1:0]   col;
        logic [PH_W-1:0] ph;
    } walk_s;

    walk_s q, d;
    logic  pix_last;
    logic  [1:0][AW-1:0] tap_addr;

    // One flattened iterator over the interior; four phases per pixel.
    always_comb begin
        d        = q;
        pix_last = (q.row == RW'(ROWS - 2)) && (q.col == CW'(COLS - 2));
        if (go) begin
            d.run = 1'b1;
            d.row = RW'(1);
            d.col = CW'(1);
            d.ph  = '0;
        end else if (q.run) begin
            d.ph = q.ph + PH_W'(1);
            if (q.ph == PH_W'(PHASES - 1)) begin
                if (pix_last) begin
                    d.run = 1'b0;
                end else if (q.col == CW'(COLS - 2)) begin
                    d.col = CW'(1);
                    d.row = q.row + RW'(1);
                end else begin
                    d.col = q.col + CW'(1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    for (genvar g = 0; g < 2; g++) begin : g_port
        assign tap_addr[g] = AW'((int'(q.row) - 1 + tap_dr(2 * int'(q.ph) + g)) * COLS
                                 + int'(q.col) - 1 + tap_dc(2 * int'(q.ph) + g));
    end

    assign rd_en      = q.run;
    assign addr_a     = tap_addr[0];
    assign addr_b     = tap_addr[1];
    assign phase      = q.ph;
    assign ctr_addr   = AW'(int'(q.row) * COLS + int'(q.col));
    assign last_issue = q.run && (q.ph == PH_W'(PHASES - 1)) && pix_last;

endmodule

// File: rtl/sobel_grad.sv
module sobel_grad
    import sobel_pkg::*;
#(
    parameter int AW = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             iss_vld,
    input  logic [PH_W-1:0]  iss_ph,
    input  logic [AW-1:0]    iss_ctr,
    input  logic [PIX_W-1:0] dat_a,
    input  logic [PIX_W-1:0] dat_b,
    output logic             res_vld,
    output logic [AW-1:0]    res_addr,
    output logic [PIX_W-1:0] res_pix
);

    typedef struct packed {
        logic [TAPS-3:0][PIX_W-1:0] taps;
        logic                       r_vld;
        logic [PH_W-1:0]            r_ph;
        logic [AW-1:0]              r_ctr;
        logic                       o_vld;
        logic [AW-1:0]              o_addr;
        logic [PIX_W-1:0]           o_pix;
    } grad_s;

    grad_s q, d;
    logic [TAPS-1:0][PIX_W-1:0] t;
    int gx_v, gy_v, mag_v;

    // Six taps are held; the final pair is used straight off the ports.
    always_comb begin
        t     = {dat_b, dat_a, q.taps};
        gx_v  = (int'(t[2]) + 2 * int'(t[4]) + int'(t[7]))
              - (int'(t[0]) + 2 * int'(t[3]) + int'(t[5]));
        gy_v  = (int'(t[5]) + 2 * int'(t[6]) + int'(t[7]))
              - (int'(t[0]) + 2 * int'(t[1]) + int'(t[2]));
        mag_v = (gx_v < 0 ? -gx_v : gx_v) + (gy_v < 0 ? -gy_v : gy_v);

        d       = q;
        d.r_vld = iss_vld;
        d.r_ph  = iss_ph;
        d.r_ctr = iss_ctr;
        d.o_vld = 1'b0;
        if (q.r_vld) begin
            if (q.r_ph == PH_W'(PHASES - 1)) begin
                d.o_vld  = 1'b1;
                d.o_addr = q.r_ctr;
                d.o_pix  = (mag_v > 255) ? 8'hFF : mag_v[PIX_W-1:0];
            end else begin
                d.taps[{q.r_ph, 1'b0}] = dat_a;
                d.taps[{q.r_ph, 1'b1}] = dat_b;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign res_vld  = q.o_vld;
    assign res_addr = q.o_addr;
    assign res_pix  = q.o_pix;

endmodule

// File: rtl/sobel_edge_engine.sv
module sobel_edge_engine
    import sobel_pkg::*;
#(
    parameter  int ROWS = 512,
    parameter  int COLS = 512,
    localparam int AW   = $clog2(ROWS * COLS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic             done,
    output logic             rd_en_a,
    output logic [AW-1:0]    rd_addr_a,
    input  logic [PIX_W-1:0] rd_data_a,
    output logic             rd_en_b,
    output logic [AW-1:0]    rd_addr_b,
    input  logic [PIX_W-1:0] rd_data_b,
    output logic             wr_en,
    output logic [AW-1:0]    wr_addr,
    output logic [PIX_W-1:0] wr_data
);

    typedef struct packed {
        ctl_state_e st;
    } ctl_s;

    ctl_s q, d;

    logic            rim_go, rim_act, rim_last;
    logic [AW-1:0]   rim_addr;
    logic            core_go, core_rd, core_last;
    logic [AW-1:0]   core_a, core_b, core_ctr;
    logic [PH_W-1:0] core_ph;
    logic            res_vld;
    logic [AW-1:0]   res_addr;
    logic [PIX_W-1:0] res_pix;

    always_comb begin
        d       = q;
        rim_go  = 1'b0;
        core_go = 1'b0;
        case (q.st)
            ST_IDLE: if (start) begin
                d.st   = ST_RIM;
                rim_go = 1'b1;
            end
            ST_RIM: if (rim_last) begin
                d.st    = ST_CORE;
                core_go = 1'b1;
            end
            ST_CORE:  if (core_last) d.st = ST_DRAIN;
            ST_DRAIN: if (res_vld)   d.st = ST_FIN;
            default:  d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q.st <= ST_IDLE;
        else        q    <= d;
    end

    sobel_rim_walk #(.ROWS(ROWS), .COLS(COLS), .AW(AW)) u_rim (
        .clk  (clk),
        .rst_n(rst_n),
        .go   (rim_go),
        .act  (rim_act),
        .last (rim_last),
        .addr (rim_addr)
    );

    sobel_core_walk #(.ROWS(ROWS), .COLS(COLS), .AW(AW)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (core_go),
        .rd_en     (core_rd),
        .addr_a    (core_a),
        .addr_b    (core_b),
        .phase     (core_ph),
        .ctr_addr  (core_ctr),
        .last_issue(core_last)
    );

    sobel_grad #(.AW(AW)) u_grad (
        .clk     (clk),
        .rst_n   (rst_n),
        .iss_vld (core_rd),
        .iss_ph  (core_ph),
        .iss_ctr (core_ctr),
        .dat_a   (rd_data_a),
        .dat_b   (rd_data_b),
        .res_vld (res_vld),
        .res_addr(res_addr),
        .res_pix (res_pix)
    );

    assign rd_en_a   = core_rd;
    assign rd_en_b   = core_rd;
    assign rd_addr_a = core_a;
    assign rd_addr_b = core_b;

    assign wr_en   = rim_act | res_vld;
    assign wr_addr = rim_act ? rim_addr : res_addr;
    assign wr_data = rim_act ? '0 : res_pix;

    assign done = (q.st == ST_FIN);

endmodule

// File: rtl/sobel_edge_chk.sv
module sobel_edge_chk #(
    parameter  int ROWS = 512,
    parameter  int COLS = 512,
    localparam int AW   = $clog2(ROWS * COLS)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          done,
    input logic          rd_en_a,
    input logic [AW-1:0] rd_addr_a,
    input logic          rd_en_b,
    input logic [AW-1:0] rd_addr_b,
    input logic          wr_en,
    input logic [AW-1:0] wr_addr,
    input logic [7:0]    wr_data
);

    int   wa;
    logic on_rim;
    logic core_wr;
    int   gap_q;
    logic seen_q;

    always_comb begin
        wa      = int'(wr_addr);
        on_rim  = (wa / COLS == 0) || (wa / COLS == ROWS - 1)
               || (wa % COLS == 0) || (wa % COLS == COLS - 1);
        core_wr = wr_en && !on_rim;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q  <= 0;
            seen_q <= 1'b0;
        end else begin
            if (core_wr)        gap_q <= 1;
            else if (gap_q < 7) gap_q <= gap_q + 1;
            if (done)           seen_q <= 1'b0;
            else if (core_wr)   seen_q <= 1'b1;
        end
    end

    a_r4_rim_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && on_rim) |-> (wr_data == 8'd0));

    a_r6_ports_paired: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_a || rd_en_b) |-> (rd_en_a && rd_en_b && rd_addr_a != rd_addr_b));

    a_r6_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en_a |-> (int'(rd_addr_a) < ROWS * COLS && int'(rd_addr_b) < ROWS * COLS));

    a_r7_core_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (core_wr && seen_q) |-> (gap_q == 4));

    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r8_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!wr_en && !rd_en_a));

endmodule

bind sobel_edge_engine sobel_edge_chk #(.ROWS(ROWS), .COLS(COLS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .done     (done),
    .rd_en_a  (rd_en_a),
    .rd_addr_a(rd_addr_a),
    .rd_en_b  (rd_en_b),
    .rd_addr_b(rd_addr_b),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data)
);

// File: tb/tb_sobel_edge_engine.sv
module tb_sobel_edge_engine;

    localparam int CLK_PERIOD = 10;
    localparam int BH  = 6;
    localparam int BW  = 7;
    localparam int NP  = BH * BW;
    localparam int AW  = $clog2(NP);
    localparam int TMO = 4000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          done;
    logic          rd_en_a, rd_en_b, wr_en;
    logic [AW-1:0] rd_addr_a, rd_addr_b, wr_addr;
    logic [7:0]    rd_data_a = 8'd0, rd_data_b = 8'd0, wr_data;

    logic [7:0] in_mem  [NP];
    logic [7:0] out_mem [NP];

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;

    // Monitor state (written only by the monitor)
    int  wr_hits [NP];
    int  wr_total = 0, rd_cycles = 0, pair_bad = 0, order_bad = 0;
    int  done_cnt = 0, done_cyc = 0, last_wr_cyc = 0;
    int  last_core_cyc = 0, last_core_addr = 0;
    bit  core_seen = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    sobel_edge_engine #(.ROWS(BH), .COLS(BW)) dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .done     (done),
        .rd_en_a  (rd_en_a),
        .rd_addr_a(rd_addr_a),
        .rd_data_a(rd_data_a),
        .rd_en_b  (rd_en_b),
        .rd_addr_b(rd_addr_b),
        .rd_data_b(rd_data_b),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data)
    );

    always @(posedge clk) cyc <= cyc + 1;

    // Source memory: synchronous read, one cycle latency
    always @(posedge clk) begin
        if (rd_en_a) rd_data_a <= in_mem[rd_addr_a];
        if (rd_en_b) rd_data_b <= in_mem[rd_addr_b];
    end

    function automatic bit is_rim(int a);
        return (a / BW == 0) || (a / BW == BH - 1) || (a % BW == 0) || (a % BW == BW - 1);
    endfunction

    // Result memory and bookkeeping, sampled mid-cycle
    always @(negedge clk) begin
        if (rst_n) begin
            if (wr_en) begin
                out_mem[wr_addr] = wr_data;
                wr_hits[wr_addr] = wr_hits[wr_addr] + 1;
                wr_total = wr_total + 1;
                last_wr_cyc = cyc;
                if (!is_rim(int'(wr_addr))) begin
                    if (core_seen && ((cyc - last_core_cyc) != 4
                                      || int'(wr_addr) <= last_core_addr))
                        order_bad = order_bad + 1;
                    core_seen      = 1'b1;
                    last_core_cyc  = cyc;
                    last_core_addr = int'(wr_addr);
                end
            end
            if (rd_en_a) rd_cycles = rd_cycles + 1;
            if (rd_en_a != rd_en_b) pair_bad = pair_bad + 1;
            if (done) begin
                done_cnt  = done_cnt + 1;
                done_cyc  = cyc;
                core_seen = 1'b0;
            end
        end
    end

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic int px(int r, int c);
        return int'(in_mem[r * BW + c]);
    endfunction

    // Unsaturated magnitude from the kernel definitions, row/column form
    function automatic int raw_mag(int r, int c);
        int gx, gy;
        gx = (px(r-1, c+1) + 2 * px(r, c+1) + px(r+1, c+1))
           - (px(r-1, c-1) + 2 * px(r, c-1) + px(r+1, c-1));
        gy = (px(r+1, c-1) + 2 * px(r+1, c) + px(r+1, c+1))
           - (px(r-1, c-1) + 2 * px(r-1, c) + px(r-1, c+1));
        return (gx < 0 ? -gx : gx) + (gy < 0 ? -gy : gy);
    endfunction

    task automatic fill(input int mode);
        for (int r = 0; r < BH; r++) begin
            for (int c = 0; c < BW; c++) begin
                case (mode)
                    0: in_mem[r*BW+c] = 8'd0;
                    1: in_mem[r*BW+c] = 8'($urandom % 256);
                    2: in_mem[r*BW+c] = (c < BW / 2) ? 8'd0 : 8'd255;
                    3: in_mem[r*BW+c] = 8'($urandom % 16);
                    4: in_mem[r*BW+c] = ((r + c) % 2 == 1) ? 8'd255 : 8'd0;
                    default: in_mem[r*BW+c] = 8'(r * 17 + c * 3);
                endcase
            end
        end
    endtask

    task automatic pulse_start();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic run_frame(input string name, input bit inject);
        int base_hits [NP];
        int b_total, b_rd, b_pair, b_order, b_done, waited, exp_v, raw;
        string tag;
        base_hits = wr_hits;
        b_total = wr_total;
        b_rd    = rd_cycles;
        b_pair  = pair_bad;
        b_order = order_bad;
        b_done  = done_cnt;
        pulse_start();
        waited = 0;
        if (inject) begin
            repeat (8) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            repeat (40) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            waited = 50;
        end
        while (!done && waited < TMO) begin
            @(negedge clk);
            waited++;
        end
        chk("R8", {name, " done reached"}, int'(waited < TMO), 1);
        repeat (20) @(negedge clk);

        for (int a = 0; a < NP; a++) begin
            if (is_rim(a)) begin
                tag = "R4";
                exp_v = 0;
            end else begin
                raw = raw_mag(a / BW, a % BW);
                tag = (raw > 255) ? "R3" : "R2";
                exp_v = (raw > 255) ? 255 : raw;
            end
            chk(tag, $sformatf("%s pixel %0d value", name, a), int'(out_mem[a]), exp_v);
            chk("R5", $sformatf("%s pixel %0d writes", name, a), wr_hits[a] - base_hits[a], 1);
        end
        chk("R6", {name, " read cycles"}, rd_cycles - b_rd, 4 * (BH - 2) * (BW - 2));
        chk("R6", {name, " port pairing"}, pair_bad - b_pair, 0);
        chk("R7", {name, " interior order/spacing"}, order_bad - b_order, 0);
        chk(inject ? "R9" : "R8", {name, " done count"}, done_cnt - b_done, 1);
        chk("R8", {name, " done after last write"}, done_cyc, last_wr_cyc + 1);
        if (inject)
            chk("R9", {name, " total writes"}, wr_total - b_total, NP);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        fill(0);
        repeat (3) @(negedge clk);
        chk("R1", "done in reset", int'(done), 0);
        chk("R1", "wr_en in reset", int'(wr_en), 0);
        chk("R1", "rd_en_a in reset", int'(rd_en_a), 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk("R1", "done idle", int'(done), 0);
        chk("R1", "wr_en idle", int'(wr_en), 0);
        chk("R1", "rd_en_b idle", int'(rd_en_b), 0);

        run_frame("flat", 1'b0);
        fill(2); run_frame("step", 1'b0);
        fill(5); run_frame("ramp", 1'b0);
        fill(3); run_frame("lowrand", 1'b0);
        fill(1); run_frame("rand_a", 1'b0);
        fill(4); run_frame("checker_inj", 1'b1);
        fill(1); run_frame("rand_inj", 1'b1);
        for (int k = 0; k < 4; k++) begin
            fill(k % 2 == 0 ? 1 : 3);
            run_frame($sformatf("rand_loop%0d", k), 1'b0);
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule